// File: doc/BRIEF.md
# UART Transmit Holding Stage with Serializer

This block is the transmit side of an asynchronous serial port. The host offers one character at a time on a write strobe and an 8-bit data port. A single holding register stores the character until a shift register is free to send it. A ready flag tells the host when the holding register can take a new character. Writes made while the flag is clear are dropped without any effect. Writes made while the transmitter is switched off are dropped in the same way. The host is expected to poll the flag and to write only while it is high.

The serializer sends 8N1 frames on the serial output. A frame is a low start bit, eight data bits with the least significant bit first, and a high stop bit. Each bit is held for 16 pulses of an external baud tick. The stop bit of one frame can be followed at once by the start bit of the next, with no idle time between them. An empty flag reports that the holding register is free and the serializer is idle.

The serializer is a state machine with four states. TX_IDLE holds the line high. It moves to TX_START when a held character is taken. TX_START drives the low start bit and moves to TX_DATA at the end of that bit. TX_DATA shifts out eight bits and moves to TX_STOP after the last one. TX_STOP drives the high stop bit. At the end of the stop bit it goes back to TX_START if a character is waiting and the transmitter is enabled, and otherwise to TX_IDLE.

Top module: `uart_tx_hold`

## Requirements
- R1: During and after reset, `txd` is 1, `tx_empty` is 1 and `tx_ready` equals `tx_en`.
- R2: `tx_ready` is 1 exactly when `tx_en` is 1 and no character is held. A strobe while `tx_ready` is 1 stores `wr_data`, and `tx_ready` reads 0 from the next cycle.
- R3: A strobe while `tx_ready` is 0 leaves the held character unchanged. No frame is ever sent for such a write.
- R4: The serializer takes the held character on the clock edge where the start bit begins. On that same edge `tx_ready` returns to 1.
- R5: A strobe given in the cycle where the character is taken is ignored. A strobe one cycle later is accepted.
- R6: A frame is a 0 start bit, 8 data bits LSB first and a 1 stop bit. Each bit lasts 16 `baud_tick` pulses, whatever the spacing of those pulses in clock cycles.
- R7: If a character is held when the stop bit ends, the next start bit begins on that same edge. With a tick in every cycle, frame starts are exactly 160 cycles apart.
- R8: `tx_empty` is 1 exactly when no character is held and the serializer is in TX_IDLE. While it is 1, `txd` is 1.
- R9: Dropping `tx_en` lets the frame in progress finish. A held character is kept and is not started until `tx_en` returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_en | input | 1 | Transmitter enable |
| wr_stb | input | 1 | Host write strobe, one cycle per write |
| wr_data | input | 8 | Character offered by the host |
| baud_tick | input | 1 | One pulse per sixteenth of a bit time |
| txd | output | 1 | Serial output, high when idle |
| tx_ready | output | 1 | Holding register can accept a write |
| tx_empty | output | 1 | Nothing held and serializer idle |

## Verification
Two events can fall in the same clock cycle: the serializer taking the held character and a host write. The bench holds the strobe high with a sacrificial byte for the whole time the flag is clear. That covers the edge of the take. On the first cycle the flag reads high, the bench swaps in a second byte. The frame that follows must carry the second byte, so the write made on the take edge is shown to be dropped. The same take edge is also checked against the end of a stop bit, where it must start the next frame with no gap: the bench measures the distance between frame starts across a back-to-back sweep of all 256 byte values.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_START = 2'd1,
        TX_DATA  = 2'd2,
        TX_STOP  = 2'd3
    } tx_state_t;
endpackage

// File: rtl/uart_tx_holdreg.sv
module uart_tx_holdreg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic              hold_valid,
    output logic [DATA_W-1:0] hold_data,
    output logic              ready
);
    logic accept;

    // Host may write only while enabled and nothing is waiting
    assign ready  = tx_en && !hold_valid;
    assign accept = wr_stb && ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_valid <= 1'b0;
            hold_data  <= '0;
        end else if (accept) begin
            hold_valid <= 1'b1;
            hold_data  <= wr_data;
        end else if (take) begin
            hold_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
    import uart_tx_pkg::*;
#(
    parameter int DATA_W        = 8,
    parameter int TICKS_PER_BIT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              baud_tick,
    input  logic              hold_valid,
    input  logic [DATA_W-1:0] hold_data,
    output logic              take,
    output logic              busy,
    output logic              txd
);
    localparam int CNT_W = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TICKS_PER_BIT - 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

    tx_state_t         state_q, state_d;
    logic [CNT_W-1:0]  tick_cnt;
    logic [IDX_W-1:0]  bit_idx;
    logic [DATA_W-1:0] shreg;
    logic              bit_end;
    logic              can_take;

    assign bit_end  = baud_tick && (tick_cnt == CNT_LAST);
    assign can_take = tx_en && hold_valid;

    // Next state and take decision
    always_comb begin
        state_d = state_q;
        take    = 1'b0;
        unique case (state_q)
            TX_IDLE: begin
                if (can_take) begin
                    take    = 1'b1;
                    state_d = TX_START;
                end
            end
            TX_START: begin
                if (bit_end) state_d = TX_DATA;
            end
            TX_DATA: begin
                if (bit_end && (bit_idx == IDX_LAST)) state_d = TX_STOP;
            end
            TX_STOP: begin
                if (bit_end) begin
                    if (can_take) begin
                        take    = 1'b1;
                        state_d = TX_START;
                    end else begin
                        state_d = TX_IDLE;
                    end
                end
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    // Bit timing and data shifting
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_cnt <= '0;
            bit_idx  <= '0;
            shreg    <= '0;
        end else if (take) begin
            tick_cnt <= '0;
            bit_idx  <= '0;
            shreg    <= hold_data;
        end else if ((state_q != TX_IDLE) && baud_tick) begin
            if (bit_end) begin
                tick_cnt <= '0;
                if (state_q == TX_DATA) begin
                    shreg   <= shreg >> 1;
                    bit_idx <= bit_idx + 1'b1;
                end
            end else begin
                tick_cnt <= tick_cnt + 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            TX_IDLE:  txd = 1'b1;
            TX_START: txd = 1'b0;
            TX_DATA:  txd = shreg[0];
            TX_STOP:  txd = 1'b1;
        endcase
        busy = (state_q != TX_IDLE);
    end
endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
    parameter int DATA_W        = 8,
    parameter int TICKS_PER_BIT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              baud_tick,
    output logic              txd,
    output logic              tx_ready,
    output logic              tx_empty
);
    logic              hold_valid;
    logic [DATA_W-1:0] hold_data;
    logic              take;
    logic              busy;

    uart_tx_holdreg #(.DATA_W(DATA_W)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_en      (tx_en),
        .wr_stb     (wr_stb),
        .wr_data    (wr_data),
        .take       (take),
        .hold_valid (hold_valid),
        .hold_data  (hold_data),
        .ready      (tx_ready)
    );

    uart_tx_shifter #(.DATA_W(DATA_W), .TICKS_PER_BIT(TICKS_PER_BIT)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_en      (tx_en),
        .baud_tick  (baud_tick),
        .hold_valid (hold_valid),
        .hold_data  (hold_data),
        .take       (take),
        .busy       (busy),
        .txd        (txd)
    );

    assign tx_empty = !hold_valid && !busy;
endmodule

// File: rtl/uart_tx_hold_chk.sv
module uart_tx_hold_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tx_en,
    input logic              wr_stb,
    input logic              txd,
    input logic              tx_ready,
    input logic              tx_empty,
    input logic              take,
    input logic [DATA_W-1:0] hold_data
);
    p_write_clears_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && tx_ready) |=> (!tx_ready && !tx_empty));

    p_blocked_write_no_change_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !tx_ready) |=> $stable(hold_data));

    p_take_starts_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !txd);

    p_empty_line_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> txd);

    p_no_take_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |-> !take);
endmodule

bind uart_tx_hold uart_tx_hold_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_en     (tx_en),
    .wr_stb    (wr_stb),
    .txd       (txd),
    .tx_ready  (tx_ready),
    .tx_empty  (tx_empty),
    .take      (take),
    .hold_data (hold_data)
);

// File: tb/uart_tx_hold_bench.sv
`timescale 1ns/1ps
module uart_tx_hold_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_en = 1'b1;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       baud_tick = 1'b0;
    logic       txd, tx_ready, tx_empty;

    int checks = 0;
    int errors = 0;
    longint cyc = 0;
    int tick_period = 1;
    int tick_cnt = 0;

    logic [7:0] rx_buf   [0:299];
    logic       rx_ok    [0:299];
    longint     rx_start [0:299];
    int         rx_count = 0;

    uart_tx_hold u_uart_tx_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_en     (tx_en),
        .wr_stb    (wr_stb),
        .wr_data   (wr_data),
        .baud_tick (baud_tick),
        .txd       (txd),
        .tx_ready  (tx_ready),
        .tx_empty  (tx_empty)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Baud tick source: one pulse every tick_period cycles
    initial begin
        forever begin
            @(negedge clk);
            baud_tick = (tick_cnt == 0);
            tick_cnt = (tick_cnt + 1 >= tick_period) ? 0 : tick_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait_ticks(input int n);
        int c = 0;
        while (c < n) begin
            @(posedge clk);
            if (baud_tick) c++;
        end
        @(negedge clk);
    endtask

    // Frame monitor: samples the middle of every bit
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && txd == 1'b0) begin
                longint st;
                logic [7:0] d;
                logic sb, sp;
                st = cyc;
                wait_ticks(8);
                sb = txd;
                for (int i = 0; i < 8; i++) begin
                    wait_ticks(16);
                    d[i] = txd;
                end
                wait_ticks(16);
                sp = txd;
                rx_buf[rx_count]   = d;
                rx_ok[rx_count]    = !sb && sp;
                rx_start[rx_count] = st;
                rx_count++;
            end
        end
    end

    task automatic put(input logic [7:0] b);
        @(negedge clk);
        while (!tx_ready) @(negedge clk);
        wr_stb  = 1'b1;
        wr_data = b;
        @(negedge clk);
        wr_stb  = 1'b0;
    endtask

    task automatic wait_frames(input int n);
        while (rx_count < n) @(negedge clk);
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        summary();
    end

    initial begin
        int base;
        // R1: reset state, with and without enable
        repeat (3) @(negedge clk);
        chk(txd == 1'b1, "R1 txd in reset", txd, 1);
        chk(tx_empty == 1'b1, "R1 empty in reset", tx_empty, 1);
        chk(tx_ready == 1'b1, "R1 ready with enable", tx_ready, 1);
        tx_en = 1'b0;
        @(negedge clk);
        chk(tx_ready == 1'b0, "R1 ready without enable", tx_ready, 0);
        tx_en = 1'b1;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(txd == 1'b1 && tx_empty == 1'b1 && tx_ready == 1'b1, "R1 after reset",
            {txd, tx_empty, tx_ready}, 7);

        // R2/R3/R4/R5: hand-off and write filtering
        base = rx_count;
        put(8'hA5);
        put(8'h3C);
        chk(tx_ready == 1'b0, "R2 ready clear after write", tx_ready, 0);
        chk(tx_empty == 1'b0, "R8 not empty while sending", tx_empty, 0);
        // Blocked writes (R3), held across the take edge (R5)
        wr_stb  = 1'b1;
        wr_data = 8'hFF;
        @(negedge clk);
        wr_data = 8'h11;
        while (!tx_ready) @(negedge clk);
        chk(txd == 1'b0, "R4 start bit on take edge", txd, 0);
        chk(rx_count == base + 1, "R4 take at end of first frame", rx_count, base + 1);
        wr_data = 8'h96;
        @(negedge clk);
        wr_stb = 1'b0;
        chk(tx_ready == 1'b0, "R5 write after take accepted", tx_ready, 0);
        wait_frames(base + 3);
        chk(rx_buf[base] == 8'hA5 && rx_ok[base], "R6 first frame", rx_buf[base], 8'hA5);
        chk(rx_buf[base+1] == 8'h3C && rx_ok[base+1], "R6 second frame", rx_buf[base+1], 8'h3C);
        chk(rx_buf[base+2] == 8'h96, "R5 take-cycle write ignored", rx_buf[base+2], 8'h96);
        chk(rx_start[base+2] - rx_start[base+1] == 160, "R7 no gap",
            rx_start[base+2] - rx_start[base+1], 160);
        while (!tx_empty) @(negedge clk);
        repeat (400) @(negedge clk);
        chk(rx_count == base + 3, "R3 blocked bytes never sent", rx_count, base + 3);
        chk(txd == 1'b1 && tx_empty == 1'b1, "R8 idle after last frame", {txd, tx_empty}, 3);

        // R6/R7: all byte values back to back
        base = rx_count;
        for (int k = 0; k < 256; k++) put(8'(k));
        wait_frames(base + 256);
        begin
            int bad_val = 0;
            int bad_gap = 0;
            for (int k = 0; k < 256; k++) begin
                if (rx_buf[base+k] != 8'(k) || !rx_ok[base+k]) begin
                    bad_val++;
                    if (bad_val == 1)
                        chk(0, "R6 sweep byte", rx_buf[base+k], k);
                end
                if (k > 0 && rx_start[base+k] - rx_start[base+k-1] != 160) begin
                    bad_gap++;
                    if (bad_gap == 1)
                        chk(0, "R7 sweep spacing", rx_start[base+k] - rx_start[base+k-1], 160);
                end
            end
            chk(bad_val == 0, "R6 sweep all values", bad_val, 0);
            chk(bad_gap == 0, "R7 sweep all gaps", bad_gap, 0);
        end
        while (!tx_empty) @(negedge clk);

        // R6: gapped ticks, bit length counted in ticks
        tick_period = 3;
        base = rx_count;
        put(8'h4B);
        wait_frames(base + 1);
        chk(rx_buf[base] == 8'h4B && rx_ok[base], "R6 gapped ticks", rx_buf[base], 8'h4B);
        while (!tx_empty) @(negedge clk);
        tick_period = 1;

        // R9/R3: disable during a frame
        base = rx_count;
        put(8'h5A);
        put(8'hC3);
        repeat (20) @(negedge clk);
        tx_en = 1'b0;
        @(negedge clk);
        chk(tx_ready == 1'b0, "R2 ready low while disabled", tx_ready, 0);
        wr_stb  = 1'b1;
        wr_data = 8'h77;
        @(negedge clk);
        wr_stb = 1'b0;
        wait_frames(base + 1);
        chk(rx_buf[base] == 8'h5A && rx_ok[base], "R9 frame finishes", rx_buf[base], 8'h5A);
        repeat (400) @(negedge clk);
        chk(rx_count == base + 1, "R9 held byte waits", rx_count, base + 1);
        chk(txd == 1'b1 && tx_empty == 1'b0, "R8 held byte not empty", {txd, tx_empty}, 2);
        tx_en = 1'b1;
        wait_frames(base + 2);
        chk(rx_buf[base+1] == 8'hC3, "R9 held byte sent after enable", rx_buf[base+1], 8'hC3);
        while (!tx_empty) @(negedge clk);
        repeat (400) @(negedge clk);
        chk(rx_count == base + 2, "R3 disabled write never sent", rx_count, base + 2);

        summary();
    end
endmodule